// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a synthesizable stand-in for a byte-wide memory whose cells can be written only once. Every cell starts at all ones. A program pulse can then clear chosen bits, but it can never set a bit back to one. Reads are gated by two active-low enables, and read data is marked valid only after programmable access delays have elapsed. Two single-bit flags take the place of the analog high-voltage conditions: `vpp_hi` stands for the raised programming supply, and `a9_hv` stands for the raised level on address bit 9.

Several devices can share one data bus. A device whose chip enable is high ignores a program pulse, so each device on the bus can be given different data. While `a9_hv` is set, the model returns one of two fixed identification bytes instead of array contents. Address bit 0 picks which byte. The `erase_all` input restores every cell to ones. It exists only to help simulation.

The data bus is split into `data_in`, `data_out` and `data_drive`. A `data_drive` value of 0 stands for a high-impedance bus. `ADDR_W` selects the depth; setting it to 13 gives 8K locations.

Top module: `otp_byte_store`

## Requirements
- R1: `data_drive` is 1 after a clock edge only if both `ce_n` and `oe_n` were sampled low at that edge. After either enable is sampled high, `data_drive` is 0 from that edge on, and `data_out` reads 0 while `data_drive` is 0.
- R2: After reset, and after any edge that samples `erase_all` high, every location reads all ones (0xFF).
- R3: A program commit happens at the first edge that samples `pgm_n` low, provided that edge also samples `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `a9_hv`=0. The commit stores the old byte ANDed with `data_in`, so bits can only change from 1 to 0. Holding `pgm_n` low does not cause another commit.
- R4: A program pulse with `vpp_hi`=0 leaves the contents unchanged.
- R5: A program pulse with `ce_n`=1 is inhibited and leaves the contents unchanged.
- R6: While `a9_hv`=1, a read returns `MFR_CODE` when `addr[0]`=0 and `DEV_CODE` when `addr[0]`=1. The other address bits and the array contents do not affect the result.
- R7: A program pulse with `a9_hv`=1 leaves the contents unchanged.
- R8: Three counters start at 1 on the first edge after an event and run from there. The events are: a change of `addr` or `a9_hv`; `ce_n` going low; `oe_n` going low. `data_valid` rises at the first edge where the address counter is at least `T_ACC`, the chip-enable counter is at least `T_CE`, and the output-enable counter is at least `T_OE`. That is the latest of the three deadlines.
- R9: If `oe_n` falls up to `T_ACC-T_OE` cycles after an address change made together with `ce_n` low, `data_valid` still rises `T_ACC` edges after the change. Any later fall delays it.
- R10: Program verify is a read with `vpp_hi`=1 and `pgm_n`=1. It returns the byte that was committed.
- R11: If `erase_all` and a program commit fall on the same edge, the erase wins and the location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; array returns to blank |
| addr | input | ADDR_W | Location address |
| data_in | input | DATA_W | Data to be programmed (bus as seen by the device) |
| data_out | output | DATA_W | Read data, 0 when not driving |
| data_drive | output | 1 | Output driver enable (0 = high impedance) |
| data_valid | output | 1 | Read data has met all access delays |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply at high level |
| a9_hv | input | 1 | High voltage on address bit 9, selects identification mode |
| erase_all | input | 1 | Simulation-only bulk erase to ones |

## Verification
Two functions can act on the same edge: a bulk erase and a qualified program commit. The bench raises `erase_all` in the very cycle in which it drops `pgm_n`, with every other program condition met. It then reads the location back through an ordinary read and expects 0xFF. A second overlap is between the read timing and late enables. Directed cases shift `ce_n` and `oe_n` relative to an address change, and the bench predicts, from the three counts, the exact edge at which `data_valid` must rise.

// File: rtl/otp_pkg.sv
package otp_pkg;

    // Where the read register takes its next byte from
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_MFR   = 2'd1,
        SRC_DEV   = 2'd2
    } rd_src_e;

    function automatic rd_src_e pick_source(input logic id_mode, input logic sel0);
        if (!id_mode)
            return SRC_ARRAY;
        return sel0 ? SRC_DEV : SRC_MFR;
    endfunction

endpackage

// File: rtl/otp_access_timer.sv
module otp_access_timer #(
    parameter int ADDR_W = 10,
    parameter int T_ACC  = 4,
    parameter int T_CE   = 4,
    parameter int T_OE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              a9_hv,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic              drive,
    output logic              valid
);
    localparam int T_MAX0 = (T_ACC > T_CE) ? T_ACC : T_CE;
    localparam int T_MAX  = (T_MAX0 > T_OE) ? T_MAX0 : T_OE;
    localparam int CW     = $clog2(T_MAX + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              a9;
        logic [CW-1:0]     acc;
        logic [CW-1:0]     ce;
        logic [CW-1:0]     oe;
        logic              drive;
        logic              valid;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    loc_chg;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == CW'(T_MAX)) ? v : v + CW'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        loc_chg   = (addr != st_q.addr) || (a9_hv != st_q.a9);
        st_d.addr = addr;
        st_d.a9   = a9_hv;
        st_d.acc  = loc_chg ? CW'(1) : sat_inc(st_q.acc);
        st_d.ce   = ce_n ? '0 : sat_inc(st_q.ce);
        st_d.oe   = oe_n ? '0 : sat_inc(st_q.oe);
        st_d.drive = !ce_n && !oe_n;
        st_d.valid = st_d.drive
                  && (st_d.acc >= CW'(T_ACC))
                  && (st_d.ce  >= CW'(T_CE))
                  && (st_d.oe  >= CW'(T_OE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign drive = st_q.drive;
    assign valid = st_q.valid;

    AST_FLOAT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> !drive); // R1

    generate
        if (T_ACC > 1) begin : g_chg_chk
            AST_CHANGE_RESTARTS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
                (addr != st_q.addr) |=> !valid); // R8
        end
    endgenerate

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_n,
    input  logic vpp_hi,
    input  logic ce_n,
    input  logic oe_n,
    input  logic a9_hv,
    output logic fire
);
    typedef struct packed {
        logic strobe_prev;
    } pstate_t;

    pstate_t ps_d, ps_q;
    logic    strobe_fall;

    always_comb begin
        ps_d             = ps_q;
        ps_d.strobe_prev = pgm_n;
        strobe_fall      = ps_q.strobe_prev && !pgm_n;
        fire             = strobe_fall && vpp_hi && !ce_n && oe_n && !a9_hv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ps_q <= '{strobe_prev: 1'b1};
        else
            ps_q <= ps_d;
    end

    AST_ONE_COMMIT_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R3

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    // Array storage: erase restores ones, a commit may only clear bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cells_q[i] <= '1;
        end else if (erase_all) begin
            for (int i = 0; i < DEPTH; i++)
                cells_q[i] <= '1;
        end else if (wr_en) begin
            cells_q[wr_addr] <= cells_q[wr_addr] & wr_mask;
        end
    end

    assign rd_data = cells_q[rd_addr];

    AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !erase_all) |=>
            ((cells_q[$past(wr_addr)] & ~$past(cells_q[wr_addr])) == '0)); // R3

    AST_ERASE_GIVES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> (cells_q[$past(wr_addr)] == '1)); // R11

endmodule

// File: rtl/otp_byte_store.sv
module otp_byte_store
    import otp_pkg::*;
#(
    parameter int              ADDR_W   = 10,
    parameter int              DATA_W   = 8,
    parameter int              T_ACC    = 4,
    parameter int              T_CE     = 4,
    parameter int              T_OE     = 2,
    parameter logic [DATA_W-1:0] MFR_CODE = 8'h3C,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'hC7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_drive,
    output logic              data_valid,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic              erase_all
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } rstate_t;

    rstate_t           rs_d, rs_q;
    logic              wr_fire;
    logic [DATA_W-1:0] arr_byte;
    rd_src_e           src;

    otp_access_timer #(
        .ADDR_W (ADDR_W),
        .T_ACC  (T_ACC),
        .T_CE   (T_CE),
        .T_OE   (T_OE)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .a9_hv (a9_hv),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .drive (data_drive),
        .valid (data_valid)
    );

    otp_prog_ctrl u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .a9_hv  (a9_hv),
        .fire   (wr_fire)
    );

    otp_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_all (erase_all),
        .wr_en     (wr_fire),
        .wr_addr   (addr),
        .wr_mask   (data_in),
        .rd_addr   (addr),
        .rd_data   (arr_byte)
    );

    always_comb begin
        rs_d = rs_q;
        src  = pick_source(a9_hv, addr[0]);
        unique case (src)
            SRC_MFR: rs_d.dout = MFR_CODE;
            SRC_DEV: rs_d.dout = DEV_CODE;
            default: rs_d.dout = arr_byte;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rs_q <= '0;
        else
            rs_q <= rs_d;
    end

    assign data_out = data_drive ? rs_q.dout : '0;

    AST_QUIET_WHEN_FLOATING: assert property (@(posedge clk) disable iff (!rst_n)
        !data_drive |-> (data_out == '0)); // R1

    AST_VALID_IMPLIES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> data_drive); // R8

    AST_INHIBIT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || a9_hv || !vpp_hi) |-> !wr_fire); // R5

    AST_ID_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (a9_hv && $past(a9_hv) && data_valid && !addr[0] && !$past(addr[0]))
            |=> (data_out == MFR_CODE) || !data_drive); // R6

endmodule

// File: tb/tb_otp_byte_store.sv
`timescale 1ns/1ps
module tb_otp_byte_store;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int T_ACC  = 4;
    localparam int T_CE   = 4;
    localparam int T_OE   = 2;
    localparam logic [7:0] MFR = 8'h3C;
    localparam logic [7:0] DEV = 8'hC7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic [DATA_W-1:0] data_out;
    logic              data_drive, data_valid;
    logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic              vpp_hi = 1'b0, a9_hv = 1'b0, erase_all = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    otp_byte_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .data_drive(data_drive), .data_valid(data_valid),
        .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .erase_all(erase_all)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Ordinary read; valid after T_ACC edges when everything moves together
    task automatic read_chk(input logic [ADDR_W-1:0] a, input logic vpp,
                            input logic [7:0] exp, input string req);
        addr = a; vpp_hi = vpp; pgm_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        cycles(T_ACC);
        check(data_valid && data_drive && data_out == exp, req, data_out, exp);
        ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0;
        cycles(1);
    endtask

    task automatic prog_pulse(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                              input logic vpp, input logic ce, input logic a9);
        addr = a; data_in = d; vpp_hi = vpp; ce_n = ce; oe_n = 1'b1; a9_hv = a9;
        cycles(1);
        pgm_n = 1'b0;
        cycles(2);
        pgm_n = 1'b1;
        cycles(1);
        ce_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
        cycles(1);
    endtask

    task automatic t_reset;
        check(!data_drive && data_out == 0, "R1 reset floating", data_drive, 0);
        check(!data_valid, "R8 reset not valid", data_valid, 0);
        read_chk(10'h000, 1'b0, 8'hFF, "R2 blank low");
        read_chk(10'h3FF, 1'b0, 8'hFF, "R2 blank high");
    endtask

    task automatic t_program;
        prog_pulse(10'h012, 8'hA5, 1'b1, 1'b0, 1'b0);
        read_chk(10'h012, 1'b0, 8'hA5, "R3 first program");
        prog_pulse(10'h012, 8'hF0, 1'b1, 1'b0, 1'b0);
        read_chk(10'h012, 1'b0, 8'hA0, "R3 AND with old");
        prog_pulse(10'h012, 8'hFF, 1'b1, 1'b0, 1'b0);
        read_chk(10'h012, 1'b0, 8'hA0, "R3 cannot set bits");
        read_chk(10'h012, 1'b1, 8'hA0, "R10 verify read");
    endtask

    task automatic t_blocked;
        prog_pulse(10'h020, 8'h00, 1'b0, 1'b0, 1'b0);
        read_chk(10'h020, 1'b0, 8'hFF, "R4 no supply");
        prog_pulse(10'h021, 8'h00, 1'b1, 1'b1, 1'b0);
        read_chk(10'h021, 1'b0, 8'hFF, "R5 inhibited");
        prog_pulse(10'h030, 8'h00, 1'b1, 1'b0, 1'b1);
        read_chk(10'h030, 1'b0, 8'hFF, "R7 id mode pulse");
    endtask

    task automatic t_ident;
        a9_hv = 1'b1;
        read_chk(10'h000, 1'b0, MFR, "R6 maker byte");
        read_chk(10'h001, 1'b0, DEV, "R6 device byte");
        read_chk(10'h012, 1'b0, MFR, "R6 other bits ignored");
        a9_hv = 1'b0;
        cycles(1);
    endtask

    // Enables fall before edge 1+delay; valid must rise exactly at exp_edge
    task automatic t_timing(input int ce_dly, input int oe_dly, input int exp_edge,
                            input string req);
        addr = addr ^ 10'h155;
        for (int k = 1; k <= exp_edge; k++) begin
            ce_n = !(k > ce_dly);
            oe_n = !(k > oe_dly);
            @(negedge clk);
            if (k >= exp_edge - 1)
                check(data_valid == (k >= exp_edge), req, data_valid, k >= exp_edge);
        end
        oe_n = 1'b1;
        cycles(1);
        check(!data_drive && data_out == 0, "R1 float after oe release", data_drive, 0);
        ce_n = 1'b1;
        cycles(1);
    endtask

    task automatic t_float_ce;
        addr = 10'h012; ce_n = 1'b0; oe_n = 1'b0;
        cycles(T_ACC);
        check(data_drive, "R1 driving", data_drive, 1);
        ce_n = 1'b1;
        cycles(1);
        check(!data_drive && !data_valid, "R1 float after ce release", data_drive, 0);
        oe_n = 1'b1;
        cycles(1);
    endtask

    task automatic t_erase_race;
        addr = 10'h040; data_in = 8'h00; vpp_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b1;
        cycles(1);
        pgm_n = 1'b0; erase_all = 1'b1;
        cycles(1);
        erase_all = 1'b0;
        cycles(1);
        pgm_n = 1'b1; ce_n = 1'b1; vpp_hi = 1'b0;
        cycles(1);
        read_chk(10'h040, 1'b0, 8'hFF, "R11 erase beats commit");
        read_chk(10'h012, 1'b0, 8'hFF, "R2 erase clears programmed");
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset;
        t_program;
        t_blocked;
        t_ident;
        t_timing(0, 0, T_ACC, "R8 all together");
        t_timing(2, 2, 2 + T_CE, "R8 late chip enable");
        t_timing(0, T_ACC - T_OE, T_ACC, "R9 late oe within slack");
        t_timing(0, T_ACC - T_OE + 1, T_ACC + 1, "R9 late oe beyond slack");
        t_float_ce;
        t_erase_race;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule